// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire (I2C/SMBus) target that holds a 256-byte memory. A single internal offset pointer serves every kind of access. The block watches SCL and SDA through a synchronizer running on its own system clock. From those lines it detects START, repeated START and STOP, recognises its 7-bit address, and shifts bytes in and out MSB first. It drives the bus only by pulling SDA low through an open-drain enable output.

The first data byte of a write loads the offset pointer, and any further bytes are stored from there. Reads return successive bytes starting at the pointer. No length byte is sent ahead of a block read. A transaction that carries only the address byte (a quick command) is acknowledged and leaves memory and pointer untouched. The device address is a fixed base plus a 3-bit strap, so up to eight instances, each with its own memory, can share one bus. A parallel init port preloads the memory.

Top module: `smbus_eeprom_tgt`

## Requirements
- R1: After reset the offset pointer is 0 and SDA is released (sda_pull low).
- R2: The address byte is ACKed (SDA pulled low on the 9th clock) only when its upper 7 bits equal BASE_ADDR plus strap_idx; otherwise SDA stays released for the rest of that transaction and nothing changes.
- R3: The first data byte after a write address (bit 0 = 0) loads the offset pointer; a write holding only that byte stores nothing.
- R4: Each later byte in the same write is stored at the pointer, which then advances by one modulo 256, so a store at 255 is followed by a store at 0.
- R5: Each read byte (address bit 0 = 1) is the memory byte at the pointer, sent MSB first; the pointer advances by one after the byte's 8th clock, wrapping 255 to 0, with no leading length byte, also after a repeated START.
- R6: A master NACK on the 9th clock of a read byte ends the transfer: SDA stays released on all further clocks until the next START.
- R7: A quick command (address byte then STOP, either R/W value) is ACKed and changes neither memory nor pointer.
- R8: A START or STOP arriving before the 8th bit of a data byte discards that partial byte without any memory write; the pointer keeps its last committed value.
- R9: A cycle with init_we high writes init_data at init_addr; the port takes priority over a bus store in the same cycle.
- R10: The target ACKs every byte written to it while it is addressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_idx | input | 3 | Instance index added to the base address |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| init_we | input | 1 | Preload write strobe |
| init_addr | input | OFF_W | Preload byte address |
| init_data | input | 8 | Preload byte value |

## Verification
The bench builds the block with its default parameters: base address 0x50, an 8-bit offset and a two-stage synchronizer. With these the full 256-byte wrap of both writes and reads can be reached in a handful of bytes near address 0xFE. The strap is held at 2 and then at 7, so a match at 0x57 and a rejection of the previously valid 0x52 are both exercised. A bit-level master model drives the bus with several system clocks per SCL phase, so the synchronizer and the edge timing of ACK and data drive are covered.

// File: rtl/smbus_eeprom_tgt.sv
module smbus_eeprom_tgt #(
  parameter logic [6:0]  BASE_ADDR   = 7'h50,
  parameter int unsigned OFF_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       strap_idx,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  input  logic             init_we,
  input  logic [OFF_W-1:0] init_addr,
  input  logic [7:0]       init_data
);
  localparam int unsigned DEPTH = 1 << OFF_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } st_t;

  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_in};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_in};
      scl_q <= scl_s[SYNC_STAGES-1];
      sda_q <= sda_s[SYNC_STAGES-1];
    end
  end

  wire scl      = scl_s[SYNC_STAGES-1];
  wire sda      = sda_s[SYNC_STAGES-1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;

  st_t              state;
  logic [3:0]       cnt;
  logic [7:0]       shreg;
  logic [OFF_W-1:0] off;
  logic             first, rw, hit, drive;
  logic [7:0]       mem [DEPTH];

  wire [6:0] dev_addr  = BASE_ADDR + {4'b0000, strap_idx};
  wire [7:0] rx_byte   = {shreg[6:0], sda};
  wire [7:0] rd_byte   = mem[off];
  wire       wr_commit = (state == ST_WR) && scl_rise && (cnt == 4'd7) && !first;

  assign sda_pull = drive;

  always_ff @(posedge clk) begin
    if (init_we)        mem[init_addr] <= init_data;
    else if (wr_commit) mem[off]       <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
      off   <= '0;
      first <= 1'b0;
      rw    <= 1'b0;
      hit   <= 1'b0;
      drive <= 1'b0;
    end else if (start_c) begin
      state <= ST_ADDR;
      cnt   <= '0;
      drive <= 1'b0;
      first <= 1'b1;
    end else if (stop_c) begin
      state <= ST_IDLE;
      cnt   <= '0;
      drive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg <= rx_byte;
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              rw  <= sda;
              hit <= (shreg[6:0] == dev_addr);
            end
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (hit) begin
              drive <= 1'b1;
              state <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state <= ST_RD;
              shreg <= rd_byte;
              drive <= ~rd_byte[7];
            end else begin
              state <= ST_WR;
              drive <= 1'b0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shreg <= rx_byte;
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              if (first) begin
                off   <= rx_byte[OFF_W-1:0];
                first <= 1'b0;
              end else begin
                off <= off + 1'b1;
              end
            end
          end else if (scl_fall && cnt == 4'd8) begin
            drive <= 1'b1;
            state <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            drive <= 1'b0;
            cnt   <= '0;
            state <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) off <= off + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              drive <= 1'b0;
              state <= ST_RACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              drive <= ~shreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise && sda) begin
            state <= ST_IDLE;
          end else if (scl_fall) begin
            cnt   <= '0;
            shreg <= rd_byte;
            drive <= ~rd_byte[7];
            state <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !drive);

  p_nack_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK && scl_rise && sda && !start_c && !stop_c) |=> (state == ST_IDLE && !drive));

  p_mismatch_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && scl_fall && cnt == 4'd8 && !hit) |=> (state == ST_IDLE && !drive));

  p_store_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (off == $past(off) + 1'b1));

  p_read_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && scl_rise && cnt == 4'd7) |=> (off == $past(off) + 1'b1));

  p_abort_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> (off == $past(off) && !drive));

  p_write_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WACK) |-> drive);

endmodule

// File: tb/smbus_eeprom_tgt_bench.sv
module smbus_eeprom_tgt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap = 3'd2;
  logic       m_scl = 1'b1;
  logic       m_low = 1'b0;
  logic       sda_pull;
  logic       init_we = 1'b0;
  logic [7:0] init_addr = '0;
  logic [7:0] init_data = '0;
  wire        sda_bus = ~(m_low | sda_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_eeprom_tgt u_smbus_eeprom_tgt (
    .clk(clk), .rst_n(rst_n), .strap_idx(strap),
    .scl_in(m_scl), .sda_in(sda_bus), .sda_pull(sda_pull),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mdl [256];
  logic [7:0] moff = 8'h00;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_v;
  event       got_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hq;
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic bstart;
    m_low = 1'b0; hq;
    m_scl = 1'b1; hq;
    m_low = 1'b1; hq;
    m_scl = 1'b0; hq;
  endtask

  task automatic bstop;
    m_low = 1'b1; hq;
    m_scl = 1'b1; hq;
    m_low = 1'b0; hq;
  endtask

  task automatic sbit(input bit b);
    m_low = ~b; hq;
    m_scl = 1'b1; hq;
    m_scl = 1'b0; hq;
  endtask

  task automatic rbit(output bit b);
    m_low = 1'b0; hq;
    m_scl = 1'b1; hq;
    b = sda_bus;
    m_scl = 1'b0; hq;
  endtask

  task automatic wbyte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) sbit(v[i]);
    rbit(a);
    acked = ~a;
  endtask

  task automatic rbyte(input bit ack_it, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    sbit(~ack_it);
  endtask

  task automatic read_seq(input int n, input string tag);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mdl[moff]);
      tag_q.push_back(tag);
      moff = moff + 8'd1;
      rbyte(k != n - 1, v);
      got_v = v;
      ->got_ev;
    end
  endtask

  function automatic logic [6:0] my_addr();
    return 7'h50 + {4'b0000, strap};
  endfunction

  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard-underflow R5", got_v, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got_v == e, t, got_v, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    repeat (5) @(posedge clk);
    #1;
    chk(sda_pull == 1'b0, "R1 sda released in reset", sda_pull, 0);
    rst_n = 1'b1;

    // R9 preload
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #1;
      init_we = 1'b1; init_addr = i[7:0]; init_data = i[7:0] ^ 8'hA5;
      mdl[i] = i[7:0] ^ 8'hA5;
    end
    @(posedge clk); #1;
    init_we = 1'b0;
    hq;
    chk(sda_pull == 1'b0, "R1 sda released after reset", sda_pull, 0);

    // R1/R5: pointer starts at 0, two sequential reads
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    chk(a, "R2 address ack read", a, 1);
    read_seq(2, "R1 R5 read from reset offset");
    bstop;

    // R3: offset-only write, then fresh read
    bstart;
    wbyte({my_addr(), 1'b0}, a);
    chk(a, "R2 address ack write", a, 1);
    wbyte(8'h10, a);
    chk(a, "R10 offset byte ack", a, 1);
    moff = 8'h10;
    bstop;
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    read_seq(1, "R3 offset-only write then read");
    bstop;

    // R4/R10: write across 255 -> 0
    bstart;
    wbyte({my_addr(), 1'b0}, a);
    wbyte(8'hFE, a);
    moff = 8'hFE;
    wbyte(8'h11, a); chk(a, "R10 data ack 1", a, 1); mdl[moff] = 8'h11; moff++;
    wbyte(8'h22, a); chk(a, "R10 data ack 2", a, 1); mdl[moff] = 8'h22; moff++;
    wbyte(8'h33, a); chk(a, "R4 data ack wrap", a, 1); mdl[moff] = 8'h33; moff++;
    bstop;

    // R5: set offset, repeated START, read across wrap
    bstart;
    wbyte({my_addr(), 1'b0}, a);
    wbyte(8'hFE, a);
    moff = 8'hFE;
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    chk(a, "R5 ack after repeated start", a, 1);
    read_seq(3, "R4 R5 read across wrap");
    bstop;

    // R2: mismatched address ignored
    bstart;
    wbyte({my_addr() + 7'd1, 1'b0}, a);
    chk(!a, "R2 mismatch nack", a, 0);
    wbyte(8'h00, a);
    chk(!a, "R2 mismatch data nack", a, 0);
    wbyte(8'h77, a);
    bstop;
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    read_seq(1, "R2 offset untouched by mismatch");
    bstop;

    // R7: quick commands
    bstart;
    wbyte({my_addr(), 1'b0}, a);
    chk(a, "R7 quick write ack", a, 1);
    bstop;
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    chk(a, "R7 quick read ack", a, 1);
    bstop;
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    read_seq(2, "R7 quick commands leave offset");
    bstop;

    // R8: partial byte then STOP
    bstart;
    wbyte({my_addr(), 1'b0}, a);
    wbyte(8'h40, a);
    moff = 8'h40;
    sbit(1'b1); sbit(1'b1); sbit(1'b0); sbit(1'b0);
    bstop;
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    read_seq(1, "R8 partial byte before stop dropped");
    bstop;

    // R8: partial byte then repeated START
    bstart;
    wbyte({my_addr(), 1'b0}, a);
    wbyte(8'h50, a);
    moff = 8'h50;
    sbit(1'b0); sbit(1'b1); sbit(1'b1);
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    read_seq(1, "R8 partial byte before restart dropped");
    bstop;

    // R6: NACK ends drive
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    read_seq(1, "R6 byte before nack");
    begin
      bit all_hi;
      bit b;
      all_hi = 1'b1;
      for (int i = 0; i < 9; i++) begin
        rbit(b);
        all_hi = all_hi & b;
      end
      chk(all_hi, "R6 sda released after nack", all_hi, 1);
    end
    bstop;
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    read_seq(1, "R6 single advance after nack");
    bstop;

    // R9: init port mid-run
    @(posedge clk); #1;
    init_we = 1'b1; init_addr = 8'h30; init_data = 8'h5C;
    mdl[8'h30] = 8'h5C;
    @(posedge clk); #1;
    init_we = 1'b0;
    bstart;
    wbyte({my_addr(), 1'b0}, a);
    wbyte(8'h30, a);
    moff = 8'h30;
    bstart;
    wbyte({my_addr(), 1'b1}, a);
    read_seq(1, "R9 init write visible");
    bstop;

    // R2: different strap
    strap = 3'd7;
    hq;
    bstart;
    wbyte({7'h57, 1'b0}, a);
    chk(a, "R2 strap 7 ack", a, 1);
    wbyte(8'h20, a);
    moff = 8'h20;
    bstop;
    bstart;
    wbyte({7'h52, 1'b1}, a);
    chk(!a, "R2 old address rejected", a, 0);
    bstop;
    bstart;
    wbyte({7'h57, 1'b1}, a);
    read_seq(1, "R2 strap 7 read");
    bstop;

    hq;
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule